// File: doc/BRIEF.md
# Indirect Memory and Peripheral Access Window

This block gives a host a small register port through which it reaches an internal word-addressed SRAM and an internal peripheral register space. It does so indirectly. The host first loads an address register. It then reads or writes the matching data register. The block turns each data access into a strobe on the internal SRAM bus or on the peripheral bus, and returns read data to the host one cycle later with a valid strobe.

Memory accesses use two independent pointers, one for reads and one for writes. Each pointer holds a full 32-bit byte address and steps forward by one 32-bit word on every data access. Peripheral accesses use their own read and write address words. Each of those words holds a register offset and a transfer size, and the address does not step. A further register passes a transmit-queue write index and a queue selector to the rest of the chip as a one-cycle strobe.

All data accesses depend on the access-granted input, which means the internal resources are awake. When the grant is low, a data access is dropped, a read returns a fixed error word, and a sticky error flag is set.

Top module: `iw_window`

## Requirements
- R1: After reset both memory pointers and both peripheral address words read back as 0, the error flag is 0, and no bus strobe, read-valid or queue strobe is active.
- R2: With the grant high, a host write to select 2 drives mem_wr in the same cycle, with mem_addr equal to bits MEM_AW+1..2 of the write pointer, and afterwards the write pointer (read back through select 1) has advanced by 4.
- R3: With the grant high, a host read of select 3 drives mem_rd in the same cycle from the read pointer. The SRAM word is returned on hst_rdata with hst_rvalid exactly one cycle later, and the read pointer (select 0) advances by 4.
- R4: The read pointer (select 0) and the write pointer (select 1) are independent: memory writes never move the read pointer and memory reads never move the write pointer. A read of any address select returns its value one cycle later with hst_rvalid.
- R5: Memory pointers are 32-bit and wrap, so a data access at 0xFFFFFFFC leaves the pointer at 0x00000000.
- R6: A peripheral address word (select 4 for write, select 5 for read) keeps the offset in bits 15..0 and the size in bits 25..24. All other bits read back as 0.
- R7: With the grant high, a host write to select 6 drives prph_wr at the write offset with byte enables 0001, 0011, 0111 or 1111 for sizes 0, 1, 2 and 3. The peripheral write address does not change.
- R8: With the grant high, a host read of select 7 returns the peripheral word one cycle later, with the bytes above the read size forced to zero. The peripheral read address does not change.
- R9: With the grant high, a host write to select 8 raises q_stb for exactly the next cycle, with q_idx taken from written bits 7..0 and q_sel from bits 11..8.
- R10: With the grant low, writes to selects 2, 6 and 8 and reads of selects 3 and 7 produce no bus strobe, no queue strobe and no pointer change. Such a read returns ERR_PATTERN (default 0xBAD0ACCE) with hst_rvalid one cycle later. Each such access sets err_flag.
- R11: err_flag stays set until the host writes select 9, which clears it. A read of select 9 returns the flag in bit 0.
- R12: When hst_wr_en and hst_rd_en are both high, only the write is carried out, and no hst_rvalid follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_grant | input | 1 | Internal resources awake and accessible |
| hst_wr_en | input | 1 | Host register write |
| hst_rd_en | input | 1 | Host register read |
| hst_sel | input | 4 | Host register select |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid with hst_rvalid |
| hst_rvalid | output | 1 | Read data valid, one cycle after the read |
| mem_addr | output | MEM_AW | SRAM word address |
| mem_wr | output | 1 | SRAM write strobe |
| mem_rd | output | 1 | SRAM read strobe |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, one cycle after mem_rd |
| prph_addr | output | PRPH_AW | Peripheral register offset |
| prph_wr | output | 1 | Peripheral write strobe |
| prph_rd | output | 1 | Peripheral read strobe |
| prph_be | output | 4 | Peripheral byte enables |
| prph_wdata | output | 32 | Peripheral write data |
| prph_rdata | input | 32 | Peripheral read data, one cycle after prph_rd |
| q_stb | output | 1 | Queue write-index strobe |
| q_sel | output | QSEL_W | Queue selector |
| q_idx | output | QIDX_W | Queue write index |
| err_flag | output | 1 | Sticky dropped-access flag |

## Verification
The SRAM and peripheral strobes are combinational from the host inputs and show up in the same cycle as the access. Read data, hst_rvalid and q_stb appear one clock edge after the access, and pointer and error-flag updates are visible right after that same edge. The bench drives each access on a falling edge and samples the results on the next falling edge, so every read result, queue strobe and flag is taken exactly one register stage later. Pointer effects are checked through address read-back, and memory and peripheral effects through later reads compared against bench shadow models.

// File: rtl/iw_pkg.sv
// Shared register selects and byte-enable helpers for the indirect window.
// Assumes a 32-bit host data path split into four byte lanes.
package iw_pkg;

    typedef enum logic [3:0] {
        SEL_MRADDR = 4'd0,
        SEL_MWADDR = 4'd1,
        SEL_MWDATA = 4'd2,
        SEL_MRDATA = 4'd3,
        SEL_PWADDR = 4'd4,
        SEL_PRADDR = 4'd5,
        SEL_PWDATA = 4'd6,
        SEL_PRDATA = 4'd7,
        SEL_QWPTR  = 4'd8,
        SEL_ERR    = 4'd9
    } iw_sel_e;

    localparam int DW      = 32;
    localparam int NBYTES  = DW / 8;
    localparam int PSZ_LSB = 24;
    localparam int PSZ_W   = 2;

    // Size code (bytes minus one) to contiguous low-order byte enables
    function automatic logic [NBYTES-1:0] size_to_be(input logic [PSZ_W-1:0] sz);
        logic [NBYTES-1:0] be;
        for (int i = 0; i < NBYTES; i++) be[i] = (i <= int'(sz));
        return be;
    endfunction

    // Byte enables expanded to a bit mask
    function automatic logic [DW-1:0] be_to_mask(input logic [NBYTES-1:0] be);
        logic [DW-1:0] m;
        for (int i = 0; i < NBYTES; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

endpackage

// File: rtl/iw_mem_port.sv
// Memory side of the window: independent 32-bit read and write byte pointers,
// each advancing by one word per granted data access. Assumes a synchronous
// SRAM that returns read data one cycle after mem_rd.
module iw_mem_port
    import iw_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        sel,
    input  logic [DW-1:0]     wdata,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [DW-1:0]     mem_wdata,
    output logic [DW-1:0]     raddr_q,
    output logic [DW-1:0]     waddr_q
);
    localparam logic [DW-1:0] STEP = DW'(NBYTES);

    logic do_w, do_r;

    // Decode granted data accesses; a write blocks a same-cycle read
    always_comb begin
        do_w = wr_en && (sel == SEL_MWDATA) && grant;
        do_r = rd_en && !wr_en && (sel == SEL_MRDATA) && grant;
    end

    // Drive the SRAM bus straight from the decoded access
    always_comb begin
        mem_wr    = do_w;
        mem_rd    = do_r;
        mem_wdata = wdata;
        mem_addr  = do_w ? waddr_q[MEM_AW+1:2] : raddr_q[MEM_AW+1:2];
    end

    // Load or advance the write pointer
    always_ff @(posedge clk) begin
        if (!rst_n)                           waddr_q <= '0;
        else if (wr_en && sel == SEL_MWADDR)  waddr_q <= wdata;
        else if (do_w)                        waddr_q <= waddr_q + STEP;
    end

    // Load or advance the read pointer
    always_ff @(posedge clk) begin
        if (!rst_n)                           raddr_q <= '0;
        else if (wr_en && sel == SEL_MRADDR)  raddr_q <= wdata;
        else if (do_r)                        raddr_q <= raddr_q + STEP;
    end

endmodule

// File: rtl/iw_prph_port.sv
// Peripheral side of the window: a write and a read address slot, each holding
// an offset and a size code. Addresses never step. Assumes the peripheral bus
// returns read data one cycle after prph_rd.
module iw_prph_port
    import iw_pkg::*;
#(
    parameter int PRPH_AW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grant,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [3:0]         sel,
    input  logic [DW-1:0]      wdata,
    output logic [PRPH_AW-1:0] prph_addr,
    output logic               prph_wr,
    output logic               prph_rd,
    output logic [NBYTES-1:0]  prph_be,
    output logic [DW-1:0]      prph_wdata,
    output logic [PRPH_AW-1:0] pw_off,
    output logic [PSZ_W-1:0]   pw_sz,
    output logic [PRPH_AW-1:0] pr_off,
    output logic [PSZ_W-1:0]   pr_sz
);
    localparam int NSLOT = 2;

    logic [PRPH_AW-1:0] off_q [NSLOT];
    logic [PSZ_W-1:0]   sz_q  [NSLOT];
    logic do_w, do_r;

    // One address slot per direction: slot 0 writes, slot 1 reads
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [3:0] ASEL = (g == 0) ? SEL_PWADDR : SEL_PRADDR;
        // Load this slot's offset and size from a host address write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_q[g] <= '0;
                sz_q[g]  <= '0;
            end else if (wr_en && sel == ASEL) begin
                off_q[g] <= wdata[PRPH_AW-1:0];
                sz_q[g]  <= wdata[PSZ_LSB +: PSZ_W];
            end
        end
    end

    // Decode granted peripheral data accesses
    always_comb begin
        do_w = wr_en && (sel == SEL_PWDATA) && grant;
        do_r = rd_en && !wr_en && (sel == SEL_PRDATA) && grant;
    end

    // Drive the peripheral bus from the slot of the active direction
    always_comb begin
        prph_wr    = do_w;
        prph_rd    = do_r;
        prph_wdata = wdata;
        prph_addr  = do_w ? off_q[0] : off_q[1];
        prph_be    = size_to_be(do_w ? sz_q[0] : sz_q[1]);
    end

    // Expose slot contents for read-back
    always_comb begin
        pw_off = off_q[0];
        pw_sz  = sz_q[0];
        pr_off = off_q[1];
        pr_sz  = sz_q[1];
    end

endmodule

// File: rtl/iw_qptr.sv
// Queue write-pointer register: a granted host write emits a one-cycle strobe
// carrying the index and the queue selector.
module iw_qptr
    import iw_pkg::*;
#(
    parameter int QIDX_W = 8,
    parameter int QSEL_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     grant,
    input  logic                     wr_en,
    input  logic [3:0]               sel,
    input  logic [QSEL_W+QIDX_W-1:0] wfield,
    output logic                     q_stb,
    output logic [QSEL_W-1:0]        q_sel,
    output logic [QIDX_W-1:0]        q_idx
);
    logic do_q;

    // Decode a granted queue-pointer write
    always_comb do_q = wr_en && (sel == SEL_QWPTR) && grant;

    // Register strobe and fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_stb <= 1'b0;
            q_sel <= '0;
            q_idx <= '0;
        end else begin
            q_stb <= do_q;
            if (do_q) begin
                q_idx <= wfield[QIDX_W-1:0];
                q_sel <= wfield[QIDX_W +: QSEL_W];
            end
        end
    end

endmodule

// File: rtl/iw_resp.sv
// Read return and error tracking: registers each host read for one cycle,
// selects SRAM, peripheral or register data, substitutes the error word for
// dropped reads, and keeps the sticky error flag.
module iw_resp
    import iw_pkg::*;
#(
    parameter logic [DW-1:0] ERR_PATTERN = 32'hBAD0ACCE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [3:0]       sel,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [DW-1:0]    prph_rdata,
    input  logic [PSZ_W-1:0] pr_sz,
    input  logic [DW-1:0]    raddr,
    input  logic [DW-1:0]    waddr,
    input  logic [DW-1:0]    pw_word,
    input  logic [DW-1:0]    pr_word,
    input  logic [DW-1:0]    q_word,
    output logic [DW-1:0]    hst_rdata,
    output logic             hst_rvalid,
    output logic             err_flag
);
    logic             do_rd, gated_rd, gated_wr;
    logic [DW-1:0]    readback;
    logic [3:0]       rsel_q;
    logic             drop_q;
    logic [DW-1:0]    regval_q;
    logic [PSZ_W-1:0] rsz_q;

    // Classify the current host access
    always_comb begin
        do_rd    = rd_en && !wr_en;
        gated_rd = do_rd && (sel == SEL_MRDATA || sel == SEL_PRDATA);
        gated_wr = wr_en && (sel == SEL_MWDATA || sel == SEL_PWDATA || sel == SEL_QWPTR);
    end

    // Register values that a host read can return
    always_comb begin
        case (sel)
            SEL_MRADDR: readback = raddr;
            SEL_MWADDR: readback = waddr;
            SEL_PWADDR: readback = pw_word;
            SEL_PRADDR: readback = pr_word;
            SEL_QWPTR:  readback = q_word;
            SEL_ERR:    readback = {{(DW-1){1'b0}}, err_flag};
            default:    readback = '0;
        endcase
    end

    // Capture the read for its one-cycle return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hst_rvalid <= 1'b0;
            rsel_q     <= '0;
            drop_q     <= 1'b0;
            regval_q   <= '0;
            rsz_q      <= '0;
        end else begin
            hst_rvalid <= do_rd;
            if (do_rd) begin
                rsel_q   <= sel;
                drop_q   <= gated_rd && !grant;
                regval_q <= readback;
                rsz_q    <= pr_sz;
            end
        end
    end

    // Choose the returned word
    always_comb begin
        if (drop_q)                     hst_rdata = ERR_PATTERN;
        else if (rsel_q == SEL_MRDATA)  hst_rdata = mem_rdata;
        else if (rsel_q == SEL_PRDATA)  hst_rdata = prph_rdata & be_to_mask(size_to_be(rsz_q));
        else                            hst_rdata = regval_q;
    end

    // Sticky error: set by a dropped access, cleared by a write to its select
    always_ff @(posedge clk) begin
        if (!rst_n)                                          err_flag <= 1'b0;
        else if ((gated_rd || gated_wr) && !grant)           err_flag <= 1'b1;
        else if (wr_en && sel == SEL_ERR)                    err_flag <= 1'b0;
    end

endmodule

// File: rtl/iw_window.sv
// Top of the indirect access window. Connects the memory port, peripheral port,
// queue pointer and read return. Assumes one host access per cycle and a grant
// input that is high only while internal resources are awake.
module iw_window
    import iw_pkg::*;
#(
    parameter int             MEM_AW      = 8,
    parameter int             PRPH_AW     = 16,
    parameter int             QIDX_W      = 8,
    parameter int             QSEL_W      = 4,
    parameter logic [31:0]    ERR_PATTERN = 32'hBAD0ACCE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_grant,
    input  logic               hst_wr_en,
    input  logic               hst_rd_en,
    input  logic [3:0]         hst_sel,
    input  logic [31:0]        hst_wdata,
    output logic [31:0]        hst_rdata,
    output logic               hst_rvalid,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic               mem_wr,
    output logic               mem_rd,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    output logic [PRPH_AW-1:0] prph_addr,
    output logic               prph_wr,
    output logic               prph_rd,
    output logic [3:0]         prph_be,
    output logic [31:0]        prph_wdata,
    input  logic [31:0]        prph_rdata,
    output logic               q_stb,
    output logic [QSEL_W-1:0]  q_sel,
    output logic [QIDX_W-1:0]  q_idx,
    output logic               err_flag
);
    localparam int QW = QSEL_W + QIDX_W;

    logic [DW-1:0]      raddr_q, waddr_q;
    logic [PRPH_AW-1:0] pw_off, pr_off;
    logic [PSZ_W-1:0]   pw_sz, pr_sz;
    logic [DW-1:0]      pw_word, pr_word, q_word;

    iw_mem_port #(.MEM_AW(MEM_AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .grant(acc_grant),
        .wr_en(hst_wr_en), .rd_en(hst_rd_en), .sel(hst_sel), .wdata(hst_wdata),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
        .raddr_q(raddr_q), .waddr_q(waddr_q)
    );

    iw_prph_port #(.PRPH_AW(PRPH_AW)) u_prph (
        .clk(clk), .rst_n(rst_n), .grant(acc_grant),
        .wr_en(hst_wr_en), .rd_en(hst_rd_en), .sel(hst_sel), .wdata(hst_wdata),
        .prph_addr(prph_addr), .prph_wr(prph_wr), .prph_rd(prph_rd),
        .prph_be(prph_be), .prph_wdata(prph_wdata),
        .pw_off(pw_off), .pw_sz(pw_sz), .pr_off(pr_off), .pr_sz(pr_sz)
    );

    iw_qptr #(.QIDX_W(QIDX_W), .QSEL_W(QSEL_W)) u_q (
        .clk(clk), .rst_n(rst_n), .grant(acc_grant),
        .wr_en(hst_wr_en), .sel(hst_sel), .wfield(hst_wdata[QW-1:0]),
        .q_stb(q_stb), .q_sel(q_sel), .q_idx(q_idx)
    );

    // Assemble read-back words for the peripheral slots and queue pointer
    always_comb begin
        pw_word = '0;
        pw_word[PRPH_AW-1:0]        = pw_off;
        pw_word[PSZ_LSB +: PSZ_W]   = pw_sz;
        pr_word = '0;
        pr_word[PRPH_AW-1:0]        = pr_off;
        pr_word[PSZ_LSB +: PSZ_W]   = pr_sz;
        q_word  = '0;
        q_word[QW-1:0]              = {q_sel, q_idx};
    end

    iw_resp #(.ERR_PATTERN(ERR_PATTERN)) u_resp (
        .clk(clk), .rst_n(rst_n), .grant(acc_grant),
        .wr_en(hst_wr_en), .rd_en(hst_rd_en), .sel(hst_sel),
        .mem_rdata(mem_rdata), .prph_rdata(prph_rdata), .pr_sz(pr_sz),
        .raddr(raddr_q), .waddr(waddr_q), .pw_word(pw_word), .pr_word(pr_word),
        .q_word(q_word),
        .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid), .err_flag(err_flag)
    );

endmodule

// File: rtl/iw_window_chk.sv
// Protocol checker for iw_window, attached by bind. Relates host accesses,
// bus strobes and pointer state across cycles.
module iw_window_chk #(
    parameter int PRPH_AW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_grant,
    input logic               hst_wr_en,
    input logic               hst_rd_en,
    input logic [3:0]         hst_sel,
    input logic               hst_rvalid,
    input logic               mem_wr,
    input logic               mem_rd,
    input logic               prph_wr,
    input logic               prph_rd,
    input logic [3:0]         prph_be,
    input logic               q_stb,
    input logic               err_flag,
    input logic [31:0]        waddr_q,
    input logic [31:0]        raddr_q,
    input logic [PRPH_AW-1:0] pw_off,
    input logic [PRPH_AW-1:0] pr_off
);
    a_r2_waddr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> waddr_q == $past(waddr_q) + 32'd4);

    a_r3_raddr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> raddr_q == $past(raddr_q) + 32'd4);

    a_r3_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rd_en && !hst_wr_en) |=> hst_rvalid);

    a_r4_write_keeps_raddr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> $stable(raddr_q));

    a_r7_prph_wr_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        prph_wr |=> $stable(pw_off));

    a_r7_be_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (prph_wr || prph_rd) |->
            (prph_be == 4'b0001 || prph_be == 4'b0011 || prph_be == 4'b0111 || prph_be == 4'b1111));

    a_r8_prph_rd_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        prph_rd |=> $stable(pr_off));

    a_r9_qstb_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr_en && hst_sel == 4'd8 && acc_grant) |=> q_stb);

    a_r10_no_bus_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_grant |-> !(mem_wr || mem_rd || prph_wr || prph_rd));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(hst_wr_en && hst_sel == 4'd9)) |=> err_flag);

    a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hst_wr_en |=> !hst_rvalid);

endmodule

bind iw_window iw_window_chk #(.PRPH_AW(PRPH_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_grant(acc_grant),
    .hst_wr_en(hst_wr_en), .hst_rd_en(hst_rd_en), .hst_sel(hst_sel),
    .hst_rvalid(hst_rvalid), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .prph_wr(prph_wr), .prph_rd(prph_rd), .prph_be(prph_be),
    .q_stb(q_stb), .err_flag(err_flag),
    .waddr_q(waddr_q), .raddr_q(raddr_q), .pw_off(pw_off), .pr_off(pr_off)
);

// File: tb/iw_window_bench.sv
module iw_window_bench;
    localparam int MEM_AW = 8;
    localparam int NWORDS = 1 << MEM_AW;
    localparam logic [31:0] ERRP = 32'hBAD0ACCE;
    localparam logic [3:0] S_MRA = 4'd0, S_MWA = 4'd1, S_MWD = 4'd2, S_MRD = 4'd3,
                           S_PWA = 4'd4, S_PRA = 4'd5, S_PWD = 4'd6, S_PRD = 4'd7,
                           S_QWP = 4'd8, S_ERR = 4'd9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_grant = 1'b1;
    logic hst_wr_en = 1'b0, hst_rd_en = 1'b0;
    logic [3:0] hst_sel = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic hst_rvalid;
    logic [MEM_AW-1:0] mem_addr;
    logic mem_wr, mem_rd;
    logic [31:0] mem_wdata, mem_rdata;
    logic [15:0] prph_addr;
    logic prph_wr, prph_rd;
    logic [3:0] prph_be;
    logic [31:0] prph_wdata, prph_rdata;
    logic q_stb;
    logic [3:0] q_sel;
    logic [7:0] q_idx;
    logic err_flag;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] shadow [NWORDS];
    logic [31:0] sram   [NWORDS];
    logic [31:0] preg   [16];
    logic [31:0] pshadow[16];

    always #10 clk = ~clk;

    iw_window u_iw_window (.*);

    // SRAM model, one cycle read latency
    always @(posedge clk) begin
        if (mem_wr) sram[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= sram[mem_addr];
    end

    // Peripheral model with byte enables, one cycle read latency
    always @(posedge clk) begin
        if (prph_wr)
            for (int b = 0; b < 4; b++)
                if (prph_be[b]) preg[prph_addr[3:0]][8*b +: 8] <= prph_wdata[8*b +: 8];
        if (prph_rd) prph_rdata <= preg[prph_addr[3:0]];
    end

    function automatic logic [31:0] sz_mask(input int sz);
        logic [31:0] m = '0;
        for (int b = 0; b <= sz; b++) m[8*b +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input int sz);
        return (old & ~sz_mask(sz)) | (nw & sz_mask(sz));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        hst_wr_en = 1'b1; hst_sel = s; hst_wdata = d;
        @(negedge clk);
        hst_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [31:0] d, output logic v);
        @(negedge clk);
        hst_rd_en = 1'b1; hst_sel = s;
        @(negedge clk);
        hst_rd_en = 1'b0;
        d = hst_rdata; v = hst_rvalid;
    endtask

    task automatic rd_chk(input logic [3:0] s, input logic [31:0] exp, input string tag);
        logic [31:0] d; logic v;
        rd(s, d, v);
        check({tag, " rvalid"}, {31'b0, v}, 32'd1);
        check(tag, d, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d, base, a, pw;
        logic v;
        int len, off, sz;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NWORDS; i++) begin sram[i] = '0; shadow[i] = '0; end
        for (int i = 0; i < 16; i++) begin preg[i] = '0; pshadow[i] = '0; end
        mem_rdata = '0; prph_rdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 rvalid", {31'b0, hst_rvalid}, 32'd0);
        check("R1 err", {31'b0, err_flag}, 32'd0);
        check("R1 strobes", {28'b0, mem_wr, mem_rd, prph_wr, q_stb}, 32'd0);
        rd_chk(S_MRA, 32'd0, "R1 raddr");
        rd_chk(S_MWA, 32'd0, "R1 waddr");
        rd_chk(S_PWA, 32'd0, "R1 pwaddr");
        rd_chk(S_PRA, 32'd0, "R1 praddr");

        // R2 R3 R4 random bursts
        for (int r = 0; r < 6; r++) begin
            base = $urandom & 32'hFFFF_FFFC;
            len  = 1 + ($urandom % 8);
            wr(S_MWA, base);
            a = base;
            for (int k = 0; k < len; k++) begin
                d = $urandom;
                shadow[a[MEM_AW+1:2]] = d;
                wr(S_MWD, d);
                a = a + 4;
            end
            rd_chk(S_MWA, base + 32'(4 * len), "R2 waddr advance");
            wr(S_MRA, base);
            a = base;
            for (int k = 0; k < len; k++) begin
                rd_chk(S_MRD, shadow[a[MEM_AW+1:2]], "R3 mem read data");
                a = a + 4;
            end
            rd_chk(S_MRA, base + 32'(4 * len), "R3 raddr advance");
            rd_chk(S_MWA, base + 32'(4 * len), "R4 waddr untouched by reads");
        end

        // R5 wrap
        wr(S_MWA, 32'hFFFF_FFFC);
        wr(S_MWD, 32'h1111_AAAA); shadow[NWORDS-1] = 32'h1111_AAAA;
        rd_chk(S_MWA, 32'h0000_0000, "R5 waddr wrap");
        wr(S_MWD, 32'h2222_BBBB); shadow[0] = 32'h2222_BBBB;
        wr(S_MRA, 32'hFFFF_FFFC);
        rd_chk(S_MRD, 32'h1111_AAAA, "R5 read last word");
        rd_chk(S_MRA, 32'h0000_0000, "R5 raddr wrap");
        rd_chk(S_MRD, 32'h2222_BBBB, "R5 read word zero");

        // R6 address word fields
        wr(S_PWA, 32'hFFFF_FFFF);
        rd_chk(S_PWA, 32'h0300_FFFF, "R6 pwaddr fields");
        pw = $urandom;
        wr(S_PRA, pw);
        rd_chk(S_PRA, pw & 32'h0300_FFFF, "R6 praddr fields");

        // R7 R8 each size
        for (int s = 0; s < 4; s++) begin
            off = $urandom % 16; sz = s;
            d = $urandom;
            pw = {6'b0, 2'(sz), 8'b0, 16'(off)};
            wr(S_PWA, pw);
            pshadow[off] = merge(pshadow[off], d, sz);
            wr(S_PWD, d);
            rd_chk(S_PWA, pw, "R7 pwaddr no step");
            wr(S_PRA, {6'b0, 2'b11, 8'b0, 16'(off)});
            rd_chk(S_PRD, pshadow[off], "R7 byte-enable merge");
            wr(S_PRA, {6'b0, 2'(sz), 8'b0, 16'(off)});
            rd_chk(S_PRD, pshadow[off] & sz_mask(sz), "R8 sized read");
            rd_chk(S_PRA, {6'b0, 2'(sz), 8'b0, 16'(off)}, "R8 praddr no step");
        end

        // R9 queue pointer
        wr(S_QWP, 32'hFFFF_F5A7);
        check("R9 q strobe", {31'b0, q_stb}, 32'd1);
        check("R9 q fields", {20'b0, q_sel, q_idx}, 32'h0000_05A7);
        @(negedge clk);
        check("R9 q strobe single", {31'b0, q_stb}, 32'd0);

        // R10 grant low
        acc_grant = 1'b0;
        wr(S_MWA, 32'h0000_0010);
        wr(S_MWD, 32'hDEAD_0001);
        rd_chk(S_MWA, 32'h0000_0010, "R10 waddr held");
        check("R10 err set", {31'b0, err_flag}, 32'd1);
        wr(S_MRA, 32'h0000_0010);
        rd_chk(S_MRD, ERRP, "R10 mem read error word");
        rd_chk(S_MRA, 32'h0000_0010, "R10 raddr held");
        rd_chk(S_PRD, ERRP, "R10 prph read error word");
        wr(S_QWP, 32'h0000_0123);
        check("R10 no q strobe", {31'b0, q_stb}, 32'd0);
        acc_grant = 1'b1;
        rd_chk(S_MRD, shadow[4], "R10 dropped write left sram");

        // R11 sticky then clear
        check("R11 err still set", {31'b0, err_flag}, 32'd1);
        rd_chk(S_ERR, 32'd1, "R11 err readback");
        wr(S_ERR, 32'd0);
        check("R11 err cleared", {31'b0, err_flag}, 32'd0);

        // R12 write and read together
        @(negedge clk);
        hst_wr_en = 1'b1; hst_rd_en = 1'b1; hst_sel = S_MWA; hst_wdata = 32'h0000_0040;
        @(negedge clk);
        hst_wr_en = 1'b0; hst_rd_en = 1'b0;
        check("R12 no rvalid", {31'b0, hst_rvalid}, 32'd0);
        rd_chk(S_MWA, 32'h0000_0040, "R12 write done");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule